// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block produces the horizontal and vertical timing of a fixed progressive raster. A column counter advances on every clock and a line counter advances each time the column counter wraps. From their values the block derives an active-low line sync and an active-low frame sync. It also reports whether the current line carries picture and whether the current position lies inside the visible pixel rectangle.

The frame sync ends halfway along a fixed early line, not at a line boundary. An interrupt request rises on the first line below the picture area and stays set until the next frame begins. Two single-cycle strobes, one at the first position of every line and one at the first position of every frame, let downstream fetch and pixel logic align to the raster.

All timing constants are parameters. By default a line is 1024 positions and a frame is 312 lines. The visible rectangle is 640 positions wide and 256 lines tall.

Top module: `raster_sync_gen`

## Requirements
- R1: Output `x` counts up by one on every clock from 0 to 1023 and then returns to 0.
- R2: Output `y` holds while `x` is below 1023. On the clock after `x` = 1023 it advances by one, and after line 311 it returns to 0.
- R3: `hsync_n` is driven low on the clock after a cycle with `x` = 0 and driven high on the clock after a cycle with `x` = 75. It is therefore low exactly while `x` is 1 to 75.
- R4: `vsync_n` is driven low on the clock after the cycle at `y` = 0, `x` = 0. It is driven high on the clock after the cycle at `y` = 2, `x` = 512.
- R5: `in_frame` is high exactly while `y` is between 38 and 293 inclusive.
- R6: `read_window` is high exactly while `in_frame` is high and `x` is between 256 and 895 inclusive.
- R7: `irq_vsync` is set on the clock after the cycle at `y` = 294, `x` = 0. It is cleared on the clock after the cycle at `y` = 0, `x` = 0.
- R8: `line_start` is high exactly when `x` = 0. `frame_start` is high exactly when `x` = 0 and `y` = 0.
- R9: While the synchronous active-high `rst` is sampled high, the next state is `x` = 0, `y` = 0, both syncs high and `irq_vsync` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-position clock |
| rst | input | 1 | Synchronous reset, active high |
| x | output | 10 | Position within the current line |
| y | output | 9 | Line within the current frame |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| in_frame | output | 1 | Current line lies in the picture area |
| read_window | output | 1 | Current position lies in the visible rectangle |
| irq_vsync | output | 1 | Frame-end interrupt request |
| line_start | output | 1 | Strobe at the first position of each line |
| frame_start | output | 1 | Strobe at the first position of each frame |

## Verification
The bound checker verifies on every cycle the counter stepping and wrapping, each set and clear event of the two syncs and the interrupt flag, the strobes, and that the visible rectangle never reaches outside the picture lines. It cannot check that the decoded lines and positions have the right numeric edges, or that the sync pulses have the right length taken as a whole. The bench shows these at chosen raster points on the default timing. It also runs a shrunken instance through several whole frames, which is where the interrupt clear at frame wrap and the reset of a set interrupt become visible.

// File: rtl/raster_pkg.sv
`timescale 1ns/1ps
package raster_pkg;
   localparam int unsigned DEF_H_TOTAL       = 1024;
   localparam int unsigned DEF_HSYNC_END     = 75;
   localparam int unsigned DEF_HACT_FIRST    = 256;
   localparam int unsigned DEF_HACT_COUNT    = 640;
   localparam int unsigned DEF_V_TOTAL       = 312;
   localparam int unsigned DEF_VSYNC_END_LN  = 2;
   localparam int unsigned DEF_VSYNC_END_POS = 512;
   localparam int unsigned DEF_VACT_FIRST    = 38;
   localparam int unsigned DEF_VACT_COUNT    = 256;

   function automatic int unsigned cnt_width(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/rs_axis_counter.sv
`timescale 1ns/1ps
module rs_axis_counter #(
   parameter int unsigned LIMIT = 1024,
   parameter int unsigned W     = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         adv,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = W'(LIMIT - 1);

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (adv)
         cnt <= (cnt == TOP) ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/rs_range_decode.sv
`timescale 1ns/1ps
module rs_range_decode #(
   parameter int unsigned W     = 10,
   parameter int unsigned FIRST = 0,
   parameter int unsigned COUNT = 1
) (
   input  logic [W-1:0] val,
   output logic         hit
);
   localparam logic [W-1:0] LO = W'(FIRST);
   localparam logic [W-1:0] HI = W'(FIRST + COUNT - 1);

   generate
      if (FIRST == 0) begin : g_from_zero
         assign hit = (val <= HI);
      end else begin : g_bounded
         assign hit = (val >= LO) && (val <= HI);
      end
   endgenerate
endmodule

// File: rtl/rs_event_flag.sv
`timescale 1ns/1ps
module rs_event_flag #(
   parameter logic INIT = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic to_one,
   input  logic to_zero,
   output logic q
);
   always_ff @(posedge clk) begin
      if (rst)
         q <= INIT;
      else if (to_zero)
         q <= 1'b0;
      else if (to_one)
         q <= 1'b1;
   end
endmodule

// File: rtl/raster_sync_gen.sv
`timescale 1ns/1ps
module raster_sync_gen
   import raster_pkg::*;
#(
   parameter int unsigned H_TOTAL       = DEF_H_TOTAL,
   parameter int unsigned HSYNC_END     = DEF_HSYNC_END,
   parameter int unsigned HACT_FIRST    = DEF_HACT_FIRST,
   parameter int unsigned HACT_COUNT    = DEF_HACT_COUNT,
   parameter int unsigned V_TOTAL       = DEF_V_TOTAL,
   parameter int unsigned VSYNC_END_LN  = DEF_VSYNC_END_LN,
   parameter int unsigned VSYNC_END_POS = DEF_VSYNC_END_POS,
   parameter int unsigned VACT_FIRST    = DEF_VACT_FIRST,
   parameter int unsigned VACT_COUNT    = DEF_VACT_COUNT,
   localparam int unsigned XW = cnt_width(H_TOTAL),
   localparam int unsigned YW = cnt_width(V_TOTAL)
) (
   input  logic          clk,
   input  logic          rst,
   output logic [XW-1:0] x,
   output logic [YW-1:0] y,
   output logic          hsync_n,
   output logic          vsync_n,
   output logic          in_frame,
   output logic          read_window,
   output logic          irq_vsync,
   output logic          line_start,
   output logic          frame_start
);
   localparam int unsigned IRQ_LINE = VACT_FIRST + VACT_COUNT;

   // elaboration-time parameter checks
   generate
      if (H_TOTAL < 2 || V_TOTAL < 2) begin : g_bad_total
         $error("raster_sync_gen: totals must be at least 2");
      end
      if (HSYNC_END == 0 || HSYNC_END >= H_TOTAL) begin : g_bad_hs
         $error("raster_sync_gen: HSYNC_END out of range");
      end
      if (HACT_COUNT == 0 || HACT_FIRST + HACT_COUNT > H_TOTAL) begin : g_bad_hact
         $error("raster_sync_gen: horizontal window out of range");
      end
      if (VACT_COUNT == 0 || IRQ_LINE >= V_TOTAL) begin : g_bad_vact
         $error("raster_sync_gen: vertical window leaves no line for the interrupt");
      end
      if (VSYNC_END_LN >= V_TOTAL || VSYNC_END_POS >= H_TOTAL
          || (VSYNC_END_LN == 0 && VSYNC_END_POS == 0)) begin : g_bad_vs
         $error("raster_sync_gen: frame sync end out of range");
      end
   endgenerate

   logic x_last;
   logic at_top;
   logic hs_done;
   logic vs_done;
   logic irq_hit;
   logic line_hit;
   logic col_hit;

   assign x_last = (x == XW'(H_TOTAL - 1));

   rs_axis_counter #(.LIMIT(H_TOTAL), .W(XW)) u_xcnt (
      .clk(clk), .rst(rst), .adv(1'b1), .cnt(x)
   );

   rs_axis_counter #(.LIMIT(V_TOTAL), .W(YW)) u_ycnt (
      .clk(clk), .rst(rst), .adv(x_last), .cnt(y)
   );

   assign line_start  = (x == '0);
   assign at_top      = line_start && (y == '0);
   assign frame_start = at_top;
   assign hs_done     = (x == XW'(HSYNC_END));
   assign vs_done     = (y == YW'(VSYNC_END_LN)) && (x == XW'(VSYNC_END_POS));
   assign irq_hit     = line_start && (y == YW'(IRQ_LINE));

   rs_event_flag #(.INIT(1'b1)) u_hsync (
      .clk(clk), .rst(rst), .to_one(hs_done), .to_zero(line_start), .q(hsync_n)
   );

   rs_event_flag #(.INIT(1'b1)) u_vsync (
      .clk(clk), .rst(rst), .to_one(vs_done), .to_zero(at_top), .q(vsync_n)
   );

   rs_event_flag #(.INIT(1'b0)) u_irq (
      .clk(clk), .rst(rst), .to_one(irq_hit), .to_zero(at_top), .q(irq_vsync)
   );

   rs_range_decode #(.W(YW), .FIRST(VACT_FIRST), .COUNT(VACT_COUNT)) u_vwin (
      .val(y), .hit(line_hit)
   );

   rs_range_decode #(.W(XW), .FIRST(HACT_FIRST), .COUNT(HACT_COUNT)) u_hwin (
      .val(x), .hit(col_hit)
   );

   assign in_frame    = line_hit;
   assign read_window = line_hit && col_hit;
endmodule

// File: rtl/raster_sync_chk.sv
`timescale 1ns/1ps
module raster_sync_chk #(
   parameter int unsigned H_TOTAL       = 1024,
   parameter int unsigned HSYNC_END     = 75,
   parameter int unsigned V_TOTAL       = 312,
   parameter int unsigned VSYNC_END_LN  = 2,
   parameter int unsigned VSYNC_END_POS = 512,
   parameter int unsigned IRQ_LINE      = 294,
   parameter int unsigned XW            = 10,
   parameter int unsigned YW            = 9
) (
   input logic          clk,
   input logic          rst,
   input logic [XW-1:0] x,
   input logic [YW-1:0] y,
   input logic          hsync_n,
   input logic          vsync_n,
   input logic          in_frame,
   input logic          read_window,
   input logic          irq_vsync,
   input logic          line_start,
   input logic          frame_start
);
   localparam logic [XW-1:0] XTOP = XW'(H_TOTAL - 1);
   localparam logic [YW-1:0] YTOP = YW'(V_TOTAL - 1);

   p_x_step_r1: assert property (@(posedge clk) disable iff (rst)
      (x != XTOP) |=> (x == XW'($past(x) + 1)));
   p_x_wrap_r1: assert property (@(posedge clk) disable iff (rst)
      (x == XTOP) |=> (x == '0));
   p_y_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (x != XTOP) |=> $stable(y));
   p_y_step_r2: assert property (@(posedge clk) disable iff (rst)
      (x == XTOP && y != YTOP) |=> (y == YW'($past(y) + 1)));
   p_y_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      (x == XTOP && y == YTOP) |=> (y == '0));
   p_hs_fall_r3: assert property (@(posedge clk) disable iff (rst)
      (x == '0) |=> !hsync_n);
   p_hs_rise_r3: assert property (@(posedge clk) disable iff (rst)
      (x == XW'(HSYNC_END)) |=> hsync_n);
   p_vs_fall_r4: assert property (@(posedge clk) disable iff (rst)
      (x == '0 && y == '0) |=> !vsync_n);
   p_vs_rise_r4: assert property (@(posedge clk) disable iff (rst)
      (x == XW'(VSYNC_END_POS) && y == YW'(VSYNC_END_LN)) |=> vsync_n);
   p_win_in_lines_r6: assert property (@(posedge clk) disable iff (rst)
      read_window |-> in_frame);
   p_irq_set_r7: assert property (@(posedge clk) disable iff (rst)
      (x == '0 && y == YW'(IRQ_LINE)) |=> irq_vsync);
   p_irq_clr_r7: assert property (@(posedge clk) disable iff (rst)
      (x == '0 && y == '0) |=> !irq_vsync);
   p_ls_single_r8: assert property (@(posedge clk) disable iff (rst)
      line_start |=> !line_start);
   p_fs_in_ls_r8: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> (line_start && y == '0));
   p_reset_state_r9: assert property (@(posedge clk)
      rst |=> (x == '0 && y == '0 && hsync_n && vsync_n && !irq_vsync));
endmodule

bind raster_sync_gen raster_sync_chk #(
   .H_TOTAL(H_TOTAL), .HSYNC_END(HSYNC_END), .V_TOTAL(V_TOTAL),
   .VSYNC_END_LN(VSYNC_END_LN), .VSYNC_END_POS(VSYNC_END_POS),
   .IRQ_LINE(VACT_FIRST + VACT_COUNT), .XW(XW), .YW(YW)
) u_chk (
   .clk(clk), .rst(rst), .x(x), .y(y), .hsync_n(hsync_n), .vsync_n(vsync_n),
   .in_frame(in_frame), .read_window(read_window), .irq_vsync(irq_vsync),
   .line_start(line_start), .frame_start(frame_start)
);

// File: tb/raster_sync_gen_test.sv
`timescale 1ns/1ps
module raster_sync_gen_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #2.5 clk = ~clk;

   int total = 0;
   int bad   = 0;
   int n     = 0;
   bit mon_en = 1'b0;
   bit done   = 1'b0;

   // default-timing instance
   logic [9:0] x;
   logic [8:0] y;
   logic hs, vs, inf, rw, irq, ls, fs;

   raster_sync_gen uut (
      .clk(clk), .rst(rst), .x(x), .y(y), .hsync_n(hs), .vsync_n(vs),
      .in_frame(inf), .read_window(rw), .irq_vsync(irq),
      .line_start(ls), .frame_start(fs)
   );

   // shrunken instance, swept over whole frames
   localparam int S_H = 32, S_HS = 5, S_HA = 8, S_HC = 16;
   localparam int S_V = 20, S_VSL = 2, S_VSP = 16, S_VA = 3, S_VC = 10;
   logic [4:0] sx, sy;
   logic s_hs, s_vs, s_inf, s_rw, s_irq, s_ls, s_fs;

   raster_sync_gen #(
      .H_TOTAL(S_H), .HSYNC_END(S_HS), .HACT_FIRST(S_HA), .HACT_COUNT(S_HC),
      .V_TOTAL(S_V), .VSYNC_END_LN(S_VSL), .VSYNC_END_POS(S_VSP),
      .VACT_FIRST(S_VA), .VACT_COUNT(S_VC)
   ) uut_small (
      .clk(clk), .rst(rst), .x(sx), .y(sy), .hsync_n(s_hs), .vsync_n(s_vs),
      .in_frame(s_inf), .read_window(s_rw), .irq_vsync(s_irq),
      .line_start(s_ls), .frame_start(s_fs)
   );

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s at n=%0d: actual=%0d expected=%0d", tag, n, act, exp);
      end
   endtask

   typedef struct packed {
      int unsigned n;
      logic [9:0]  x;
      logic [8:0]  y;
      logic hs, vs, inf, rw, irq, ls, fs;
   } vec_t;

   // cycles after reset release and the expected default-timing outputs
   localparam vec_t TBL [16] = '{
      '{0,     10'd0,    9'd0,  1,1,0,0,0,1,1},
      '{1,     10'd1,    9'd0,  0,0,0,0,0,0,0},
      '{75,    10'd75,   9'd0,  0,0,0,0,0,0,0},
      '{76,    10'd76,   9'd0,  1,0,0,0,0,0,0},
      '{1024,  10'd0,    9'd1,  1,0,0,0,0,1,0},
      '{1025,  10'd1,    9'd1,  0,0,0,0,0,0,0},
      '{2560,  10'd512,  9'd2,  1,0,0,0,0,0,0},
      '{2561,  10'd513,  9'd2,  1,1,0,0,0,0,0},
      '{38188, 10'd300,  9'd37, 1,1,0,0,0,0,0},
      '{38912, 10'd0,    9'd38, 1,1,1,0,0,1,0},
      '{39167, 10'd255,  9'd38, 1,1,1,0,0,0,0},
      '{39168, 10'd256,  9'd38, 1,1,1,1,0,0,0},
      '{39807, 10'd895,  9'd38, 1,1,1,1,0,0,0},
      '{39808, 10'd896,  9'd38, 1,1,1,0,0,0,0},
      '{40959, 10'd1023, 9'd39, 1,1,1,0,0,0,0},
      '{40960, 10'd0,    9'd40, 1,1,1,0,0,1,0}
   };

   // independent reference for the shrunken instance, checked every cycle
   always @(negedge clk) begin
      if (mon_en && !done) begin
         int ex, ey, p, vs_end, irq_from;
         bit e_hs, e_vs, e_inf, e_rw, e_irq;
         ex = n % S_H;
         ey = (n / S_H) % S_V;
         p  = ey * S_H + ex;
         vs_end   = S_VSL * S_H + S_VSP;
         irq_from = (S_VA + S_VC) * S_H + 1;
         e_hs  = !(ex >= 1 && ex <= S_HS);
         e_vs  = !(p >= 1 && p <= vs_end);
         e_inf = (ey >= S_VA && ey < S_VA + S_VC);
         e_rw  = e_inf && ex >= S_HA && ex < S_HA + S_HC;
         e_irq = (p >= irq_from) || (p == 0 && n > 0);
         chk("R1 small x", int'(sx), ex);
         chk("R2 small y", int'(sy), ey);
         chk("R3 small hsync_n", int'(s_hs), int'(e_hs));
         chk("R4 small vsync_n", int'(s_vs), int'(e_vs));
         chk("R5 small in_frame", int'(s_inf), int'(e_inf));
         chk("R6 small read_window", int'(s_rw), int'(e_rw));
         chk("R7 small irq_vsync", int'(s_irq), int'(e_irq));
         chk("R8 small line_start", int'(s_ls), int'(ex == 0));
         chk("R8 small frame_start", int'(s_fs), int'(p == 0));
      end
   end

   task automatic advance_to(int target);
      while (n < target) begin
         @(posedge clk);
         n++;
      end
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      n = 0;
      mon_en = 1'b1;

      // table walk on default timing
      for (int i = 0; i < 16; i++) begin
         advance_to(int'(TBL[i].n));
         chk("R1 x", int'(x), int'(TBL[i].x));
         chk("R2 y", int'(y), int'(TBL[i].y));
         chk("R3 hsync_n", int'(hs), int'(TBL[i].hs));
         chk("R4 vsync_n", int'(vs), int'(TBL[i].vs));
         chk("R5 in_frame", int'(inf), int'(TBL[i].inf));
         chk("R6 read_window", int'(rw), int'(TBL[i].rw));
         chk("R7 irq_vsync", int'(irq), int'(TBL[i].irq));
         chk("R8 line_start", int'(ls), int'(TBL[i].ls));
         chk("R8 frame_start", int'(fs), int'(TBL[i].fs));
      end

      // mid-frame reset: the small instance has its interrupt set here
      chk("R7 small irq set before reset", int'(s_irq), 1);
      @(negedge clk);
      mon_en = 1'b0;
      rst = 1'b1;
      @(posedge clk);
      #1;
      chk("R9 x", int'(x), 0);
      chk("R9 y", int'(y), 0);
      chk("R9 hsync_n", int'(hs), 1);
      chk("R9 vsync_n", int'(vs), 1);
      chk("R9 irq_vsync small", int'(s_irq), 0);
      @(posedge clk);
      #1;
      chk("R9 x held", int'(x), 0);
      chk("R9 hsync_n held", int'(hs), 1);
      @(negedge clk);
      rst = 1'b0;
      n = 0;
      mon_en = 1'b1;
      advance_to(700);
      chk("R1 x after reset", int'(x), 700);
      chk("R3 hsync_n after reset", int'(hs), 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog expired at n=%0d: actual=running expected=finished", n);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule